// File: doc/BRIEF.md
# Dual Parallel Port Peripheral

This block gives an 8-bit processor two 8-bit general-purpose I/O ports, A and B. Each port has an output latch and a direction register with one bit per pin. The processor reaches these four registers over a simple bus. The bus carries a phase-2 strobe, a read/write line, a pair of chip selects of opposite polarity, a 4-bit register index and an 8-bit data path. A value written to a latch stays on the pins for as long as the direction bits make them outputs, so the processor can carry on with other work while the pins hold their state.

The phase-2 strobe, the selects and the index are sampled on the system clock `clk`. A write commits on the first clock edge after phase-2 falls. It uses the bus values captured while phase-2 was still high. Read data is combinational, and the block drives it only inside a selected read while phase-2 is high. The reset input is active low and is sampled on `clk`. It is meant to be wired to the same reset line as the processor.

Top module: `pport_dual`

## Requirements
- R1: While `rst_n` is low at a clock edge, both output latches and both direction registers clear to 0. Every pin is then an input with output value 0, and the direction registers read back as 0.
- R2: The block is selected only when `sel_hi` is 1 and `sel_lo_n` is 0. A write made with any other combination of the two selects changes no register.
- R3: The register index `reg_idx` maps as follows: 0 is the port B output latch, 1 is the port A output latch, 2 is the port B direction register and 3 is the port A direction register. A direction register reads back the value last written to it.
- R4: A direction bit of 1 sets the matching `*_dir` output bit to 1, which makes that pin an output. The pin then carries the matching bit of the output latch on `*_out`. A direction bit of 0 makes the pin an input.
- R5: An output latch keeps its value through any number of other bus accesses until a new write to its own index replaces it.
- R6: A write takes effect only with `rd_wr_n` = 0 and a falling edge of `ph2`. An access with `rd_wr_n` = 1, or a selected cycle in which `ph2` never rises, changes no register.
- R7: Reading a port's output-latch index returns a mixed value. Each bit whose direction bit is 1 gives the latch bit, and each bit whose direction bit is 0 gives the live pin input.
- R8: Indices 4 to 15 read as 0, and writes to them change no register. In particular they do not alias onto indices 0 to 3.
- R9: `bus_doe` is 1 only during a selected read with `ph2` high, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low reset, sampled on `clk` |
| ph2 | input | 1 | Bus phase-2 strobe |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| reg_idx | input | 4 | Register index |
| bus_din | input | 8 | Write data from the processor |
| bus_dout | output | 8 | Read data to the processor |
| bus_doe | output | 1 | Drive enable for `bus_dout` |
| porta_in | input | 8 | Live pin levels of port A |
| porta_out | output | 8 | Port A output latch |
| porta_dir | output | 8 | Port A per-pin output enable |
| portb_in | input | 8 | Live pin levels of port B |
| portb_out | output | 8 | Port B output latch |
| portb_dir | output | 8 | Port B per-pin output enable |

## Verification
The properties assume that `ph2` stays high for at least one clock edge and low for at least one edge between transitions. They also assume that the selects, `rd_wr_n`, `reg_idx` and `bus_din` hold steady from before `ph2` rises until after the commit edge, and that the bus is idle (`sel_hi` low) while reset is held. The stimulus changes bus inputs only at falling clock edges and keeps `ph2` high for three clocks. It holds every bus line until two clocks after `ph2` falls, and it deselects the block before asserting reset.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int DATA_W  = 8;
    localparam int IDX_W   = 4;
    localparam int N_PORTS = 2;

    // Bank order: bank 0 is port B, bank 1 is port A
    localparam int BANK_B = 0;
    localparam int BANK_A = 1;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic  sel;
        logic  wr;
        idx_t  idx;
        byte_t data;
    } bus_req_t;

    typedef struct packed {
        byte_t latch;
        byte_t dir;
    } bank_state_t;

    // Output bits show the latch; input bits show the pin
    function automatic byte_t pin_view(input byte_t latch, input byte_t dir, input byte_t pin);
        return (latch & dir) | (pin & ~dir);
    endfunction

endpackage

// File: rtl/pport_bus_capture.sv
module pport_bus_capture
    import pport_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ph2,
    input  logic     sel_hi,
    input  logic     sel_lo_n,
    input  logic     rd_wr_n,
    input  idx_t     reg_idx,
    input  byte_t    bus_din,
    output bus_req_t req,
    output logic     commit
);

    logic     ph2_q;
    bus_req_t cap;

    // Bus values are sampled while phase-2 is high
    always_ff @(posedge clk) begin
        if (ph2) begin
            cap.sel  <= sel_hi & ~sel_lo_n;
            cap.wr   <= ~rd_wr_n;
            cap.idx  <= reg_idx;
            cap.data <= bus_din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph2_q <= 1'b0;
        else        ph2_q <= ph2;
    end

    assign req    = cap;
    assign commit = ph2_q & ~ph2 & cap.sel & cap.wr;

endmodule

// File: rtl/pport_bank.sv
module pport_bank
    import pport_pkg::*;
#(
    parameter int OUT_IDX = 0,
    parameter int DIR_IDX = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        commit,
    input  bus_req_t    req,
    output bank_state_t state
);

    localparam idx_t OUT_SEL = idx_t'(OUT_IDX);
    localparam idx_t DIR_SEL = idx_t'(DIR_IDX);

    bank_state_t st_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (commit) begin
            if (req.idx == OUT_SEL) st_q.latch <= req.data;
            if (req.idx == DIR_SEL) st_q.dir   <= req.data;
        end
    end

    assign state = st_q;

endmodule

// File: rtl/pport_read_mux.sv
module pport_read_mux
    import pport_pkg::*;
#(
    parameter int NB = N_PORTS
) (
    input  idx_t                 reg_idx,
    input  bank_state_t [NB-1:0] banks,
    input  byte_t       [NB-1:0] pins,
    output byte_t                rdata
);

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NB; k++) begin
            if (reg_idx == idx_t'(k))
                rdata = pin_view(banks[k].latch, banks[k].dir, pins[k]);
            if (reg_idx == idx_t'(k + NB))
                rdata = banks[k].dir;
        end
    end

endmodule

// File: rtl/pport_dual.sv
module pport_dual
    import pport_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ph2,
    input  logic                sel_hi,
    input  logic                sel_lo_n,
    input  logic                rd_wr_n,
    input  logic [IDX_W-1:0]    reg_idx,
    input  logic [DATA_W-1:0]   bus_din,
    output logic [DATA_W-1:0]   bus_dout,
    output logic                bus_doe,
    input  logic [DATA_W-1:0]   porta_in,
    output logic [DATA_W-1:0]   porta_out,
    output logic [DATA_W-1:0]   porta_dir,
    input  logic [DATA_W-1:0]   portb_in,
    output logic [DATA_W-1:0]   portb_out,
    output logic [DATA_W-1:0]   portb_dir
);

    bus_req_t                   req;
    logic                       commit;
    bank_state_t [N_PORTS-1:0]  banks;
    byte_t       [N_PORTS-1:0]  pins;

    pport_bus_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph2      (ph2),
        .sel_hi   (sel_hi),
        .sel_lo_n (sel_lo_n),
        .rd_wr_n  (rd_wr_n),
        .reg_idx  (reg_idx),
        .bus_din  (bus_din),
        .req      (req),
        .commit   (commit)
    );

    for (genvar b = 0; b < N_PORTS; b++) begin : g_bank
        pport_bank #(
            .OUT_IDX (b),
            .DIR_IDX (b + N_PORTS)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .commit (commit),
            .req    (req),
            .state  (banks[b])
        );
    end

    assign pins[BANK_B] = portb_in;
    assign pins[BANK_A] = porta_in;

    pport_read_mux #(.NB(N_PORTS)) u_rmux (
        .reg_idx (reg_idx),
        .banks   (banks),
        .pins    (pins),
        .rdata   (bus_dout)
    );

    assign bus_doe   = sel_hi & ~sel_lo_n & rd_wr_n & ph2;

    assign porta_out = banks[BANK_A].latch;
    assign porta_dir = banks[BANK_A].dir;
    assign portb_out = banks[BANK_B].latch;
    assign portb_dir = banks[BANK_B].dir;

endmodule

// File: rtl/pport_dual_chk.sv
module pport_dual_chk
    import pport_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                ph2,
    input logic                sel_hi,
    input logic                sel_lo_n,
    input logic                rd_wr_n,
    input logic [IDX_W-1:0]    reg_idx,
    input logic [DATA_W-1:0]   bus_din,
    input logic                bus_doe,
    input logic [DATA_W-1:0]   porta_out,
    input logic [DATA_W-1:0]   porta_dir,
    input logic [DATA_W-1:0]   portb_out,
    input logic [DATA_W-1:0]   portb_dir
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (porta_out == '0 && porta_dir == '0 && portb_out == '0 && portb_dir == '0));

    // R5
    hold_without_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !($past(ph2) && !ph2)) |=>
            ($stable(porta_out) && $stable(porta_dir) && $stable(portb_out) && $stable(portb_dir)));

    // R2
    unselected_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(ph2) && !ph2 && !($past(sel_hi) && !$past(sel_lo_n))) |=>
            ($stable(porta_out) && $stable(porta_dir) && $stable(portb_out) && $stable(portb_dir)));

    // R6
    read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(ph2) && !ph2 && $past(rd_wr_n)) |=>
            ($stable(porta_out) && $stable(porta_dir) && $stable(portb_out) && $stable(portb_dir)));

    // R4
    dir_a_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(ph2) && !ph2 && $past(sel_hi) && !$past(sel_lo_n) && !$past(rd_wr_n)
         && $past(reg_idx) == 4'd3) |=> porta_dir == $past(bus_din, 2));

    // R3
    out_b_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(ph2) && !ph2 && $past(sel_hi) && !$past(sel_lo_n) && !$past(rd_wr_n)
         && $past(reg_idx) == 4'd0) |=> portb_out == $past(bus_din, 2));

    // R9
    doe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ph2 |-> !bus_doe);

    // R9
    doe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_wr_n || !sel_hi || sel_lo_n) |-> !bus_doe);

endmodule

bind pport_dual pport_dual_chk u_chk (.*);

// File: tb/pport_dual_bench.sv
module pport_dual_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ph2 = 1'b0;
    logic       sel_hi = 1'b0;
    logic       sel_lo_n = 1'b1;
    logic       rd_wr_n = 1'b1;
    logic [3:0] reg_idx = '0;
    logic [7:0] bus_din = '0;
    logic [7:0] bus_dout;
    logic       bus_doe;
    logic [7:0] porta_in = '0;
    logic [7:0] porta_out, porta_dir;
    logic [7:0] portb_in = '0;
    logic [7:0] portb_out, portb_dir;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] val;
    } exp_item_t;

    exp_item_t  exp_q[$];
    logic [7:0] act_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pport_dual u_pport_dual (
        .clk(clk), .rst_n(rst_n), .ph2(ph2), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .rd_wr_n(rd_wr_n), .reg_idx(reg_idx), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .porta_in(porta_in), .porta_out(porta_out),
        .porta_dir(porta_dir), .portb_in(portb_in), .portb_out(portb_out),
        .portb_dir(portb_dir)
    );

    // Driver side: push expected, then observed value
    task automatic expect_val(input string tag, input logic [7:0] act, input logic [7:0] exp);
        exp_item_t it;
        it.tag = tag;
        it.val = exp;
        exp_q.push_back(it);
        act_q.push_back(act);
    endtask

    // Monitor: pops and compares away from the active edge
    always @(negedge clk) begin
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            exp_item_t  e;
            logic [7:0] a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            checks++;
            if (a !== e.val) begin
                failures++;
                $display("FAIL %s actual=%02h expected=%02h", e.tag, a, e.val);
            end
        end
    end

    task automatic bus_op(input logic hi, input logic lo_n, input logic rd,
                          input logic [3:0] idx, input logic [7:0] wdata, input bit pulse,
                          output logic [7:0] rdata, output logic oe_low, output logic oe_high);
        @(negedge clk);
        sel_hi = hi; sel_lo_n = lo_n; rd_wr_n = rd; reg_idx = idx; bus_din = wdata;
        @(negedge clk);
        oe_low = bus_doe;
        ph2 = pulse;
        repeat (3) @(negedge clk);
        rdata = bus_dout;
        oe_high = bus_doe;
        ph2 = 1'b0;
        repeat (2) @(negedge clk);
        sel_hi = 1'b0; sel_lo_n = 1'b1; rd_wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        logic [7:0] r;
        logic o1, o2;
        bus_op(1'b1, 1'b0, 1'b0, idx, d, 1'b1, r, o1, o2);
    endtask

    task automatic rd(input logic [3:0] idx, output logic [7:0] d);
        logic o1, o2;
        bus_op(1'b1, 1'b0, 1'b1, idx, 8'h00, 1'b1, d, o1, o2);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic o1, o2;

        do_reset();
        // R1: reset state
        expect_val("R1 porta_dir", porta_dir, 8'h00);
        expect_val("R1 portb_dir", portb_dir, 8'h00);
        expect_val("R1 porta_out", porta_out, 8'h00);
        expect_val("R1 portb_out", portb_out, 8'h00);
        rd(4'd2, r); expect_val("R1 ddr b readback", r, 8'h00);

        // R3 R4: port B all outputs, latch 55
        wr(4'd2, 8'hFF);
        wr(4'd0, 8'h55);
        expect_val("R4 portb_dir", portb_dir, 8'hFF);
        expect_val("R4 portb_out", portb_out, 8'h55);
        rd(4'd2, r); expect_val("R3 ddr b readback", r, 8'hFF);
        rd(4'd0, r); expect_val("R7 port b all out", r, 8'h55);

        // R3 R7: port A mixed directions
        porta_in = 8'h3C;
        wr(4'd3, 8'hF0);
        wr(4'd1, 8'hA5);
        expect_val("R3 porta_dir", porta_dir, 8'hF0);
        expect_val("R3 porta_out", porta_out, 8'hA5);
        rd(4'd3, r); expect_val("R3 ddr a readback", r, 8'hF0);
        rd(4'd1, r); expect_val("R7 port a mixed", r, 8'hAC);
        porta_in = 8'hC3;
        rd(4'd1, r); expect_val("R7 port a live pins", r, 8'hA3);

        // R2: wrong select combinations
        bus_op(1'b0, 1'b0, 1'b0, 4'd0, 8'h00, 1'b1, r, o1, o2);
        expect_val("R2 sel_hi low", portb_out, 8'h55);
        bus_op(1'b1, 1'b1, 1'b0, 4'd0, 8'h00, 1'b1, r, o1, o2);
        expect_val("R2 sel_lo_n high", portb_out, 8'h55);
        bus_op(1'b0, 1'b1, 1'b0, 4'd2, 8'h00, 1'b1, r, o1, o2);
        expect_val("R2 both wrong", portb_dir, 8'hFF);

        // R6: read cycle and missing phase-2 pulse
        bus_op(1'b1, 1'b0, 1'b1, 4'd0, 8'h12, 1'b1, r, o1, o2);
        expect_val("R6 read no write", portb_out, 8'h55);
        bus_op(1'b1, 1'b0, 1'b0, 4'd0, 8'h12, 1'b0, r, o1, o2);
        expect_val("R6 no ph2 pulse", portb_out, 8'h55);

        // R8: indices above 3
        wr(4'd4, 8'h00);
        wr(4'd6, 8'h00);
        wr(4'd8, 8'h00);
        expect_val("R8 no alias out b", portb_out, 8'h55);
        expect_val("R8 no alias dir b", portb_dir, 8'hFF);
        expect_val("R8 no alias out a", porta_out, 8'hA5);
        rd(4'd5, r);  expect_val("R8 idx5 reads 0", r, 8'h00);
        rd(4'd15, r); expect_val("R8 idx15 reads 0", r, 8'h00);

        // R9: drive enable
        bus_op(1'b1, 1'b0, 1'b1, 4'd0, 8'h00, 1'b1, r, o1, o2);
        expect_val("R9 read ph2 low", {7'd0, o1}, 8'h00);
        expect_val("R9 read ph2 high", {7'd0, o2}, 8'h01);
        bus_op(1'b1, 1'b0, 1'b0, 4'd7, 8'h00, 1'b1, r, o1, o2);
        expect_val("R9 write ph2 high", {7'd0, o2}, 8'h00);
        bus_op(1'b0, 1'b0, 1'b1, 4'd0, 8'h00, 1'b1, r, o1, o2);
        expect_val("R9 unselected read", {7'd0, o2}, 8'h00);

        // R5: latch held, then overwritten
        expect_val("R5 held", portb_out, 8'h55);
        wr(4'd0, 8'hAA);
        expect_val("R5 overwrite", portb_out, 8'hAA);
        expect_val("R5 other port intact", porta_out, 8'hA5);

        // R4: port B lower half inputs
        portb_in = 8'h0F;
        wr(4'd2, 8'hF0);
        expect_val("R4 portb_dir half", portb_dir, 8'hF0);
        rd(4'd0, r); expect_val("R7 port b mixed", r, 8'hAF);

        // R1: reset in mid-run
        do_reset();
        expect_val("R1 mid porta_out", porta_out, 8'h00);
        expect_val("R1 mid portb_dir", portb_dir, 8'h00);
        portb_in = 8'h5A;
        rd(4'd0, r); expect_val("R1 inputs after reset", r, 8'h5A);

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule